// File: doc/BRIEF.md
# Extended parallel port control register slice

This block holds the control state of an extended-capabilities parallel port and exposes it to a host through a small synchronous register bus. It decodes three byte registers: an identification byte, a read-only configuration byte, and the extended control byte. The extended control byte carries the port mode, a mask for the fault interrupt, the DMA enable and the service flag. The identification and configuration bytes are visible only when the mode field selects the configuration mode, 3'b111.

The block watches the active-low fault line from the peripheral. In the port's extended mode (mode 3'b011) it turns a falling fault edge into a one-cycle error interrupt pulse. It also raises that pulse when software unmasks the interrupt while the line is already low, so a fault that arrives between a read and a write of the control byte is not lost. Status from the DMA engine and the FIFO (terminal count, forward threshold and reverse threshold) raises a one-cycle service interrupt and sets the service flag. While the flag is set, DMA and further service interrupts stay blocked until software clears it.

Top module: `ecpx_ctrl_regs`

## Requirements
- R1: When the mode field is 3'b111, a read at offset 0x400 returns 0x10.
- R2: When the mode field is 3'b111, a read at offset 0x401 returns bit 7 = 0, bit 6 = the present level of `irq_out`, bits 5:3 = parameter `IRQ_CODE` and bits 2:0 = parameter `DMA_CODE`.
- R3: Offset 0x402 is readable and writable in every mode with bits 7:5 = mode, bit 4 = fault mask, bit 3 = DMA enable, bit 2 = service flag and bits 1:0 reading 0. Offsets 0x400 and 0x401 read 0x00 in any mode other than 3'b111. Unmapped offsets and cycles without `host_rd` read 0x00. `mode_sel` always shows the mode field.
- R4: With mode 3'b011 and fault mask 0, a falling edge on `nfault` gives exactly one `err_irq` pulse within six cycles. No pulse is produced in any other mode, with the mask at 1, or on a rising edge.
- R5: A write to 0x402 that changes the fault mask from 1 to 0 and selects mode 3'b011 while `nfault` is already low gives exactly one `err_irq` pulse. The same write with `nfault` high, or a write where the mask was already 0, gives none.
- R6: `dma_allow` is high exactly when the DMA enable is 1 and the service flag is 0.
- R7: With DMA enable at 1 and the service flag at 0, a `dma_tc` cycle gives exactly one `svc_irq` pulse and sets the service flag. The threshold inputs are ignored.
- R8: With DMA enable at 0 and the service flag at 0, `wr_fifo_thresh` (when `port_reverse` = 0) or `rd_fifo_thresh` (when `port_reverse` = 1) gives exactly one `svc_irq` pulse and sets the flag. The threshold for the other direction and `dma_tc` are ignored. No event does anything while the flag is 1.
- R9: Software writing 1 to the service flag produces no `svc_irq` pulse. Writing 0 clears the flag.
- R10: After reset, 0x402 reads 0x04, `mode_sel` is 0, and `dma_allow`, `err_irq`, `svc_irq` and `irq_out` are low.
- R11: `irq_out` is the OR of `err_irq` and `svc_irq`, and every interrupt pulse lasts one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | ADDR_W | Register offset |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, combinational |
| nfault | input | 1 | Asynchronous active-low fault line |
| dma_tc | input | 1 | DMA terminal count reached |
| wr_fifo_thresh | input | 1 | Forward FIFO threshold event |
| rd_fifo_thresh | input | 1 | Reverse FIFO threshold event |
| port_reverse | input | 1 | 1 when the port transfers in the reverse direction |
| mode_sel | output | 3 | Current mode field |
| dma_allow | output | 1 | DMA may issue requests |
| err_irq | output | 1 | Fault interrupt pulse |
| svc_irq | output | 1 | Service interrupt pulse |
| irq_out | output | 1 | Combined interrupt |

## Verification
The bench builds the block with `IRQ_CODE` = 6 and `DMA_CODE` = 2, so that the configuration byte shows values that differ from the defaults and the parameters can be seen reaching the read path. With the two-stage synchronizer every fault check fits a six-cycle window. This allows a full sweep of all eight modes against both mask values for fault edges, all combinations of mode and line level for the unmask path, and every combination of DMA enable, direction, event source and prior flag value for the service logic.

// File: rtl/ecpx_pkg.sv
package ecpx_pkg;
    localparam logic [2:0] MODE_ECP = 3'b011;
    localparam logic [2:0] MODE_CFG = 3'b111;
    localparam logic [7:0] ID_BYTE  = 8'h10;

    typedef struct packed {
        logic [2:0] mode;
        logic       err_mask;
        logic       dma_en;
        logic       svc_flag;
        logic       err_pulse;
        logic       svc_pulse;
    } ecr_state_t;

    localparam ecr_state_t ECR_RESET = '{
        mode: 3'b000, err_mask: 1'b0, dma_en: 1'b0, svc_flag: 1'b1,
        err_pulse: 1'b0, svc_pulse: 1'b0
    };
endpackage

// File: rtl/ecpx_fault_sync.sv
module ecpx_fault_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic nfault,
    output logic level,
    output logic fall
);
    localparam int SH_W = SYNC_STAGES + 1;

    logic [SH_W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[SH_W-2:0], nfault};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign level = sh_q[SYNC_STAGES-1];
    assign fall  = sh_q[SYNC_STAGES] & ~sh_q[SYNC_STAGES-1];
endmodule

// File: rtl/ecpx_svc_event.sv
module ecpx_svc_event (
    input  logic dma_en,
    input  logic port_reverse,
    input  logic dma_tc,
    input  logic wr_fifo_thresh,
    input  logic rd_fifo_thresh,
    output logic event_hit
);
    logic thresh_sel;

    always_comb begin
        thresh_sel = port_reverse ? rd_fifo_thresh : wr_fifo_thresh;
        event_hit  = dma_en ? dma_tc : thresh_sel;
    end
endmodule

// File: rtl/ecpx_ctrl_regs.sv
module ecpx_ctrl_regs
    import ecpx_pkg::*;
#(
    parameter int         ADDR_W      = 11,
    parameter int         BASE_ADDR   = 'h400,
    parameter int         SYNC_STAGES = 2,
    parameter logic [2:0] IRQ_CODE    = 3'd5,
    parameter logic [2:0] DMA_CODE    = 3'd1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    input  logic              nfault,
    input  logic              dma_tc,
    input  logic              wr_fifo_thresh,
    input  logic              rd_fifo_thresh,
    input  logic              port_reverse,
    output logic [2:0]        mode_sel,
    output logic              dma_allow,
    output logic              err_irq,
    output logic              svc_irq,
    output logic              irq_out
);
    localparam logic [ADDR_W-1:0] OFF_ID  = ADDR_W'(BASE_ADDR);
    localparam logic [ADDR_W-1:0] OFF_CFG = ADDR_W'(BASE_ADDR + 1);
    localparam logic [ADDR_W-1:0] OFF_ECR = ADDR_W'(BASE_ADDR + 2);

    ecr_state_t st_d, st_q;

    logic fault_level, fault_fall, svc_event;
    logic ecr_wr, rearm_hit, edge_hit, svc_fire, cfg_vis;
    logic [1:0] wdata_unused;

    assign wdata_unused = host_wdata[1:0];

    ecpx_fault_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .nfault (nfault),
        .level  (fault_level),
        .fall   (fault_fall)
    );

    ecpx_svc_event u_evt (
        .dma_en         (st_q.dma_en),
        .port_reverse   (port_reverse),
        .dma_tc         (dma_tc),
        .wr_fifo_thresh (wr_fifo_thresh),
        .rd_fifo_thresh (rd_fifo_thresh),
        .event_hit      (svc_event)
    );

    always_comb begin
        st_d           = st_q;
        st_d.err_pulse = 1'b0;
        st_d.svc_pulse = 1'b0;

        ecr_wr    = host_wr && (host_addr == OFF_ECR);
        rearm_hit = ecr_wr && st_q.err_mask && !host_wdata[4]
                    && !fault_level && (host_wdata[7:5] == MODE_ECP);
        edge_hit  = fault_fall && !st_q.err_mask && (st_q.mode == MODE_ECP);
        svc_fire  = !st_q.svc_flag && svc_event;

        if (ecr_wr) begin
            st_d.mode     = host_wdata[7:5];
            st_d.err_mask = host_wdata[4];
            st_d.dma_en   = host_wdata[3];
            st_d.svc_flag = host_wdata[2];
        end

        st_d.err_pulse = rearm_hit || edge_hit;

        if (svc_fire) begin
            st_d.svc_flag  = 1'b1;
            st_d.svc_pulse = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ECR_RESET;
        else        st_q <= st_d;
    end

    always_comb begin
        cfg_vis    = (st_q.mode == MODE_CFG);
        host_rdata = 8'h00;
        if (host_rd) begin
            unique case (host_addr)
                OFF_ID:  host_rdata = cfg_vis ? ID_BYTE : 8'h00;
                OFF_CFG: host_rdata = cfg_vis ? {1'b0, irq_out, IRQ_CODE, DMA_CODE} : 8'h00;
                OFF_ECR: host_rdata = {st_q.mode, st_q.err_mask, st_q.dma_en,
                                       st_q.svc_flag, 2'b00};
                default: host_rdata = 8'h00;
            endcase
        end
    end

    assign mode_sel  = st_q.mode;
    assign dma_allow = st_q.dma_en && !st_q.svc_flag;
    assign err_irq   = st_q.err_pulse;
    assign svc_irq   = st_q.svc_pulse;
    assign irq_out   = st_q.err_pulse || st_q.svc_pulse;

    // R4 / R5: a fault pulse follows a cycle in which the synchronized line was low
    p_err_after_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq |-> $past(!fault_level));

    // R4: edge pulses need extended mode, unless a control write selected it
    p_err_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq |-> ($past(st_q.mode) == MODE_ECP || $past(ecr_wr)));

    // R11: pulses last one cycle
    p_err_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq |=> !err_irq);
    p_svc_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        svc_irq |=> !svc_irq);

    // R7 / R8: a service pulse leaves the flag set and needed it clear before
    p_svc_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        svc_irq |-> (st_q.svc_flag && $past(!st_q.svc_flag)));

    // R9: the flag rises without a pulse only through a control write
    p_flag_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(st_q.svc_flag) && !svc_irq) |-> $past(ecr_wr));
endmodule

// File: tb/ecpx_ctrl_regs_test.sv
`timescale 1ns/1ps
module ecpx_ctrl_regs_test;
    localparam logic [2:0] T_IRQ = 3'd6;
    localparam logic [2:0] T_DMA = 3'd2;
    localparam logic [10:0] A_ID  = 11'h400;
    localparam logic [10:0] A_CFG = 11'h401;
    localparam logic [10:0] A_ECR = 11'h402;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] host_addr = '0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        nfault = 1'b1, dma_tc = 1'b0, wr_th = 1'b0, rd_th = 1'b0, rev = 1'b0;
    logic [2:0]  mode_sel;
    logic        dma_allow, err_irq, svc_irq, irq_out;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    ecpx_ctrl_regs #(.IRQ_CODE(T_IRQ), .DMA_CODE(T_DMA)) uut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .nfault(nfault), .dma_tc(dma_tc), .wr_fifo_thresh(wr_th),
        .rd_fifo_thresh(rd_th), .port_reverse(rev), .mode_sel(mode_sel),
        .dma_allow(dma_allow), .err_irq(err_irq), .svc_irq(svc_irq), .irq_out(irq_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_ecr(input logic [7:0] d);
        @(negedge clk);
        host_addr = A_ECR; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd_now(input logic [10:0] a, output logic [7:0] d);
        host_addr = a; host_rd = 1'b1;
        #1 d = host_rdata;
        host_rd = 1'b0;
    endtask

    task automatic rd(input logic [10:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_now(a, d);
    endtask

    // samples the present cycle first, then n-1 further cycles
    task automatic count(input int n, output int ec, output int sc, output int ic, output int bad_or);
        ec = 0; sc = 0; ic = 0; bad_or = 0;
        for (int i = 0; i < n; i++) begin
            if (i != 0) @(negedge clk);
            if (err_irq) ec++;
            if (svc_irq) sc++;
            if (irq_out) ic++;
            if (irq_out != (err_irq | svc_irq)) bad_or++;
        end
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int ec, sc, ic, bo;

        repeat (3) @(negedge clk);
        // R10: reset state
        rd_now(A_ECR, d);
        check(d == 8'h04, "R10 ecr reset", d, 8'h04);
        check(mode_sel == 3'd0 && !dma_allow && !err_irq && !svc_irq && !irq_out,
              "R10 outputs reset", {mode_sel, dma_allow, err_irq, svc_irq, irq_out}, 0);
        rd_now(A_ID, d);
        check(d == 8'h00, "R3 id hidden in reset mode", d, 0);
        rst_n = 1'b1;

        // R1 R2 R3: register visibility in every mode
        for (int m = 0; m < 8; m++) begin
            logic [7:0] w;
            w = {3'(m), 5'b00100};
            wr_ecr(w);
            rd(A_ID, d);
            check(d == ((m == 7) ? 8'h10 : 8'h00), "R1 id byte", d, (m == 7) ? 8'h10 : 0);
            rd(A_CFG, d);
            check(d == ((m == 7) ? {2'b00, T_IRQ, T_DMA} : 8'h00), "R2 cfg byte",
                  d, (m == 7) ? {2'b00, T_IRQ, T_DMA} : 0);
            rd(A_ECR, d);
            check(d == w, "R3 ecr readback", d, w);
            check(mode_sel == 3'(m), "R3 mode_sel", mode_sel, m);
            rd(11'h403, d);
            check(d == 8'h00, "R3 unmapped", d, 0);
        end
        wr_ecr(8'b111_1_1_1_11);
        rd(A_ECR, d);
        check(d == 8'hFC, "R3 low bits read zero", d, 8'hFC);
        @(negedge clk);
        host_addr = A_ECR; #1;
        check(host_rdata == 8'h00, "R3 no read strobe", host_rdata, 0);

        // R2: bit 6 follows the interrupt level
        wr_ecr(8'b111_0_1_0_00);
        dma_tc = 1'b1; @(negedge clk); dma_tc = 1'b0;
        rd_now(A_CFG, d);
        check(d[6] == 1'b1, "R2 irq level high", d[6], 1);
        rd(A_CFG, d);
        check(d[6] == 1'b0, "R2 irq level low", d[6], 0);

        // R4: fault edges across all modes and masks
        for (int m = 0; m < 8; m++) begin
            for (int k = 0; k < 2; k++) begin
                int exp;
                wr_ecr({3'(m), 1'(k), 4'b0100});
                exp = (m == 3 && k == 0) ? 1 : 0;
                @(negedge clk); nfault = 1'b0;
                count(6, ec, sc, ic, bo);
                check(ec == exp, "R4 falling edge", ec, exp);
                check(ic == exp && bo == 0, "R11 irq_out follows err", ic, exp);
                @(negedge clk); nfault = 1'b1;
                count(6, ec, sc, ic, bo);
                check(ec == 0, "R4 rising edge", ec, 0);
            end
        end

        // R5: unmask while the line is low
        for (int m = 0; m < 2; m++) begin
            for (int lv = 0; lv < 2; lv++) begin
                logic [2:0] md;
                int exp;
                md = (m == 0) ? 3'b011 : 3'b000;
                wr_ecr({md, 5'b10100});
                @(negedge clk); nfault = 1'(lv);
                repeat (5) @(negedge clk);
                wr_ecr({md, 5'b00100});
                exp = (m == 0 && lv == 0) ? 1 : 0;
                count(4, ec, sc, ic, bo);
                check(ec == exp, "R5 unmask write", ec, exp);
                wr_ecr({md, 5'b00100});
                count(4, ec, sc, ic, bo);
                check(ec == 0, "R5 mask already clear", ec, 0);
                @(negedge clk); nfault = 1'b1;
                repeat (5) @(negedge clk);
            end
        end

        // R6 R7 R8: service events
        for (int de = 0; de < 2; de++)
            for (int dir = 0; dir < 2; dir++)
                for (int src = 0; src < 3; src++)
                    for (int pre = 0; pre < 2; pre++) begin
                        bit fire;
                        wr_ecr({3'b011, 1'b0, 1'(de), 1'(pre), 2'b00});
                        check(dma_allow == (de == 1 && pre == 0), "R6 dma_allow before",
                              dma_allow, (de == 1 && pre == 0));
                        rev = 1'(dir);
                        @(negedge clk);
                        dma_tc = (src == 0); wr_th = (src == 1); rd_th = (src == 2);
                        @(negedge clk);
                        dma_tc = 1'b0; wr_th = 1'b0; rd_th = 1'b0;
                        fire = (pre == 0) && ((de == 1) ? (src == 0)
                               : ((src == 1 && dir == 0) || (src == 2 && dir == 1)));
                        count(3, ec, sc, ic, bo);
                        check(sc == int'(fire), de ? "R7 tc event" : "R8 threshold event",
                              sc, fire);
                        check(ic == int'(fire) && bo == 0, "R11 irq_out follows svc", ic, fire);
                        rd(A_ECR, d);
                        check(d[2] == (pre == 1 || fire), "R8 flag after event", d[2],
                              (pre == 1 || fire));
                        check(dma_allow == (de == 1 && pre == 0 && !fire), "R6 dma_allow after",
                              dma_allow, (de == 1 && pre == 0 && !fire));
                    end

        // R9: software writes of the flag
        wr_ecr(8'b011_0_1_0_00);
        check(dma_allow == 1'b1, "R9 flag cleared", dma_allow, 1);
        wr_ecr(8'b011_0_1_1_00);
        count(3, ec, sc, ic, bo);
        check(sc == 0, "R9 write one no pulse", sc, 0);
        check(dma_allow == 1'b0, "R9 flag set by write", dma_allow, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule